// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Insertion-Order Replacement

This block translates virtual byte addresses into physical byte addresses for the memory stage of a pipelined processor. It holds a small set of page mappings in a fully associative store. When a request arrives, its virtual page number is compared against every valid mapping at once. On a match, the physical address is produced in the same cycle: the stored physical page number is joined to the untouched page offset.

When no mapping matches, the block raises a stall toward the pipeline in that same cycle. It then requests the missing translation from an external page-table walker. It holds that request, with a fixed page number, until the walker answers. The answer is written over the entry that was inserted longest ago, with no regard to how often that entry has been used since. One cycle later the block pulses a replay signal. Through that cycle the stall stays high, so the pipeline re-presents the same access, which now hits.

Pages are 4 KiB. The default store holds eight entries, and the insertion pointer wraps after the last one. Because the pointer starts at zero after reset and only moves when an entry is written, empty slots are always filled before any valid mapping is evicted.

Top module: `vtlb_top`

## Requirements
- R1: After reset every entry is invalid, so the first request to any address misses; with `req_valid` low after reset, `stall`, `hit`, `walk_req` and `replay` are all 0.
- R2: When `req_valid` is high, the block is idle, and the page number (`req_vaddr[31:12]`) matches a valid entry, `hit` is 1, `stall` is 0, and `paddr[31:12]` equals that entry's physical page number in the same cycle.
- R3: On a hit, `paddr[11:0]` equals `req_vaddr[11:0]` for every offset value, including 0x000 and 0xFFF.
- R4: A request that matches no valid entry drives `stall` to 1 in the same cycle. In the next cycle `walk_req` is 1 and `walk_vpn` equals the missing page number.
- R5: `walk_req` stays at 1 with an unchanged `walk_vpn` until a cycle in which `walk_resp_valid` is 1. A `walk_resp_valid` pulse while no walk is pending writes nothing, and a later request to that page still misses.
- R6: The edge that samples `walk_resp_valid` together with `walk_req` writes the mapping (`walk_vpn` to `walk_resp_ppn`). In the following cycle `replay` is 1 for exactly one cycle, and `stall` is still 1.
- R7: In the cycle after `replay`, the re-presented request hits and returns the physical page supplied by the walker.
- R8: A refill overwrites the entry inserted earliest. With eight entries full, a ninth distinct page evicts the first page inserted even if that page was hit just before, while the other seven still hit.
- R9: With `req_valid` low and no walk or replay in progress, `stall` and `hit` are 0 and `paddr` is 0.
- R10: While a walk is pending, changes on `req_vaddr` do not alter `walk_vpn` or end the walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A memory access is presented |
| req_vaddr | input | 32 | Virtual byte address of the access |
| hit | output | 1 | Translation found this cycle |
| paddr | output | 32 | Physical byte address, valid when `hit` is 1 (0 otherwise) |
| stall | output | 1 | Freeze the pipeline |
| replay | output | 1 | One-cycle pulse: re-issue the stalled access |
| walk_req | output | 1 | Translation request to the page-table walker |
| walk_vpn | output | 20 | Virtual page number being requested |
| walk_resp_valid | input | 1 | Walker response strobe |
| walk_resp_ppn | input | 20 | Physical page number returned by the walker |

## Verification
The hardest case is replacement order. The bench fills all eight slots, hits the oldest page several times, and forces a ninth miss. A design that tracked recent use would evict a different page, and the following re-access of the oldest page would hit instead of stalling. The bench also strobes a walker response when no walk is pending, to catch a block that writes on any response. It disturbs the request address in mid-walk, to catch a block that sends the live address to the walker. It also times the replay pulse and the release of the stall exactly. A block that dropped the stall one cycle early, or skipped the replay, would let the pipeline run ahead before the mapping became usable.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WALK   = 2'd1,
    ST_REPLAY = 2'd2
  } vtlb_state_t;
endpackage

// File: rtl/vtlb_entries.sv
module vtlb_entries #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VPN_W-1:0] lookup_vpn,
  output logic             match_any,
  output logic [PPN_W-1:0] match_ppn,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn
);
  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [ENTRIES-1:0] match_vec;

  // tag and data arrays: no reset, written at one index per cycle
  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx] <= wr_vpn;
      ppn_q[wr_idx] <= wr_ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  // parallel comparators, one per slot
  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_vec[g] = valid_q[g] && (vpn_q[g] == lookup_vpn);
    end
  endgenerate

  assign match_any = |match_vec;

  always_comb begin
    match_ppn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) match_ppn = match_ppn | ppn_q[i];
    end
  end

  // R8
  unique_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  // R1
  empty_after_reset_chk: assert property (@(posedge clk)
    rst |=> (valid_q == '0));
endmodule

// File: rtl/vtlb_victim.sv
module vtlb_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (adv) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  assign ptr = ptr_q;

  // R8
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && ptr_q == LAST) |=> (ptr_q == '0));

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr_q));
endmodule

// File: rtl/vtlb_ctrl.sv
module vtlb_ctrl
  import vtlb_pkg::*;
#(
  parameter int VPN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             match_any,
  input  logic             resp_valid,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  output logic             fill_en,
  output logic             stall,
  output logic             replay,
  output logic             idle
);
  vtlb_state_t      state_q, state_d;
  logic [VPN_W-1:0] vpn_q;
  logic             miss;

  assign idle = (state_q == ST_IDLE);
  assign miss = idle && req_valid && !match_any;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (miss) state_d = ST_WALK;
      ST_WALK:   if (resp_valid) state_d = ST_REPLAY;
      ST_REPLAY: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      vpn_q   <= '0;
    end else begin
      state_q <= state_d;
      if (miss) vpn_q <= req_vpn;
    end
  end

  assign walk_req = (state_q == ST_WALK);
  assign walk_vpn = vpn_q;
  assign fill_en  = walk_req && resp_valid;
  assign replay   = (state_q == ST_REPLAY);
  assign stall    = !idle || miss;

  // R4
  miss_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && req_valid && !match_any) |=> (walk_req && walk_vpn == $past(req_vpn)));

  // R5
  walk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (walk_req && !resp_valid) |=> (walk_req && $stable(walk_vpn)));

  // R6
  replay_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (walk_req && resp_valid) |=> (replay && stall));

  // R6
  replay_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    replay |=> !replay);
endmodule

// File: rtl/vtlb_top.sv
module vtlb_top #(
  parameter int VADDR_W  = 32,
  parameter int PADDR_W  = 32,
  parameter int OFFSET_W = 12,
  parameter int ENTRIES  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [VADDR_W-1:0]          req_vaddr,
  output logic                        hit,
  output logic [PADDR_W-1:0]          paddr,
  output logic                        stall,
  output logic                        replay,
  output logic                        walk_req,
  output logic [VADDR_W-OFFSET_W-1:0] walk_vpn,
  input  logic                        walk_resp_valid,
  input  logic [PADDR_W-OFFSET_W-1:0] walk_resp_ppn
);
  localparam int VPN_W = VADDR_W - OFFSET_W;
  localparam int PPN_W = PADDR_W - OFFSET_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0]    req_vpn;
  logic [OFFSET_W-1:0] req_off;
  logic                match_any;
  logic [PPN_W-1:0]    match_ppn;
  logic                fill_en;
  logic                idle;
  logic [IDX_W-1:0]    victim;

  assign req_vpn = req_vaddr[VADDR_W-1:OFFSET_W];
  assign req_off = req_vaddr[OFFSET_W-1:0];

  vtlb_entries #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
  ) u_entries (
    .clk(clk), .rst(rst),
    .lookup_vpn(req_vpn), .match_any(match_any), .match_ppn(match_ppn),
    .wr_en(fill_en), .wr_idx(victim), .wr_vpn(walk_vpn), .wr_ppn(walk_resp_ppn)
  );

  vtlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .adv(fill_en), .ptr(victim)
  );

  vtlb_ctrl #(.VPN_W(VPN_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vpn(req_vpn), .match_any(match_any),
    .resp_valid(walk_resp_valid),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .fill_en(fill_en),
    .stall(stall), .replay(replay), .idle(idle)
  );

  assign hit   = idle && req_valid && match_any;
  assign paddr = hit ? {match_ppn, req_off} : '0;

  // R2
  hit_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (!stall && !walk_req && !replay));

  // R9
  quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && !walk_req && !replay) |-> (!stall && !hit && paddr == '0));

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (paddr[OFFSET_W-1:0] == req_vaddr[OFFSET_W-1:0]));
endmodule

// File: tb/tb_vtlb_top.sv
module tb_vtlb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        hit;
  logic [31:0] paddr;
  logic        stall;
  logic        replay;
  logic        walk_req;
  logic [19:0] walk_vpn;
  logic        walk_resp_valid;
  logic [19:0] walk_resp_ppn;

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_q[$];

  logic [19:0] m_vpn [8];
  logic        m_val [8];
  int          m_ptr;

  always #2.5 clk = ~clk;

  vtlb_top dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .hit(hit), .paddr(paddr), .stall(stall), .replay(replay),
    .walk_req(walk_req), .walk_vpn(walk_vpn),
    .walk_resp_valid(walk_resp_valid), .walk_resp_ppn(walk_resp_ppn)
  );

  function automatic logic [19:0] walker_map(logic [19:0] v);
    return (v ^ 20'hC3A5F) + 20'h00101;
  endfunction

  function automatic bit model_has(logic [19:0] v);
    for (int i = 0; i < 8; i++) if (m_val[i] && m_vpn[i] == v) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every hit must match the oldest expected address
  always @(negedge clk) begin
    if (!rst && hit === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected hit", paddr, 32'hxxxx_xxxx);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk("R2/R3 paddr", paddr, e);
      end
    end
  end

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0;
    walk_resp_valid = 1'b0; walk_resp_ppn = '0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 1'b0;
    for (int i = 0; i < 8; i++) m_val[i] = 1'b0;
    m_ptr = 0;
  endtask

  task automatic access(logic [31:0] va, bit disturb);
    logic [19:0] vpn;
    bit          miss;
    vpn  = va[31:12];
    miss = !model_has(vpn);
    @(posedge clk); #1;
    req_valid = 1'b1; req_vaddr = va;
    if (!miss) exp_q.push_back({walker_map(vpn), va[11:0]});
    @(negedge clk);
    chk(miss ? "R4 stall on miss" : "R2 no stall on hit", {31'd0, stall}, {31'd0, miss});
    chk(miss ? "R4 no hit on miss" : "R2 hit flag", {31'd0, hit}, {31'd0, !miss});
    if (miss) begin
      @(negedge clk);
      chk("R4 walk_req", {31'd0, walk_req}, 32'd1);
      chk("R4 walk_vpn", {12'd0, walk_vpn}, {12'd0, vpn});
      if (disturb) begin
        @(posedge clk); #1; req_vaddr = ~va;
        @(negedge clk);
        chk("R10 walk_vpn held", {12'd0, walk_vpn}, {12'd0, vpn});
        chk("R10 walk still pending", {31'd0, walk_req}, 32'd1);
        @(posedge clk); #1; req_vaddr = va;
      end
      @(negedge clk);
      chk("R5 walk held", {31'd0, walk_req & stall}, 32'd1);
      @(posedge clk); #1;
      walk_resp_valid = 1'b1; walk_resp_ppn = walker_map(vpn);
      @(posedge clk); #1;
      walk_resp_valid = 1'b0; walk_resp_ppn = '0;
      m_vpn[m_ptr] = vpn; m_val[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) % 8;
      @(negedge clk);
      chk("R6 replay", {31'd0, replay}, 32'd1);
      chk("R6 stall in replay", {31'd0, stall}, 32'd1);
      @(posedge clk); #1;
      exp_q.push_back({walker_map(vpn), va[11:0]});
      @(negedge clk);
      chk("R7 hit after replay", {31'd0, hit}, 32'd1);
      chk("R6 replay one cycle", {31'd0, replay}, 32'd0);
      chk("R7 stall released", {31'd0, stall}, 32'd0);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 / R9: quiet after reset
    chk("R1 stall after reset", {31'd0, stall}, 32'd0);
    chk("R1 hit after reset", {31'd0, hit}, 32'd0);
    chk("R1 walk_req after reset", {31'd0, walk_req}, 32'd0);
    chk("R1 replay after reset", {31'd0, replay}, 32'd0);
    chk("R9 paddr idle", paddr, 32'd0);

    // R1: first access misses; R7 refill path
    access(32'h0000_1234, 1'b0);
    // R2 / R3: hits with varied offsets
    access(32'h0000_1000, 1'b0);
    access(32'h0000_1FFF, 1'b0);
    // R10: disturb address mid-walk
    access(32'hABCD_E567, 1'b1);
    access(32'hABCD_E000, 1'b0);

    // R5: response strobe with no walk pending writes nothing
    @(posedge clk); #1;
    walk_resp_valid = 1'b1; walk_resp_ppn = 20'h12345;
    @(posedge clk); #1;
    walk_resp_valid = 1'b0;
    @(negedge clk);
    chk("R5 no replay on stray response", {31'd0, replay}, 32'd0);
    chk("R9 no stall idle", {31'd0, stall}, 32'd0);
    access(32'h7777_7AAA, 1'b0); // model: still a miss

    // R8: FIFO replacement independent of use
    do_reset();
    for (int k = 0; k < 8; k++) access({20'h00100 + 20'(k), 12'h010}, 1'b0);
    for (int k = 0; k < 3; k++) access(32'h0010_0020, 1'b0); // hits on oldest
    access(32'h0010_8030, 1'b0); // ninth page, evicts 0x00100
    chk("R8 oldest evicted in model", {31'd0, model_has(20'h00100)}, 32'd0);
    access(32'h0010_0040, 1'b0); // must miss again (stall checked inside)
    access(32'h0010_3050, 1'b0); // evicted 0x00101 now; 0x00103 still hits
    access(32'h0010_7060, 1'b0);

    // R9: idle cycles
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 idle stall", {31'd0, stall}, 32'd0);
      chk("R9 idle hit", {31'd0, hit}, 32'd0);
    end
    chk("R2 scoreboard drained", exp_q.size(), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule